// File: doc/BRIEF.md
# PCI Function Power-State and MSI Control Registers

This block holds two configuration-space structures of a PCI function. The first is a two-bit power-state field that moves the function between full operation (D0) and the D3hot low-power state. The second is an MSI capability header together with its message control word. Software reaches both through a single-cycle config port. Each request carries a dword address, four byte enables and 32-bit write data, and each request is acknowledged on the next cycle.

From the stored state the block drives four things. The first is the memory/IO decode enable, which passes a decode request from the command logic through to the address decoders. The second is an interrupt gate. The third is a select between MSI and INTx signalling. The fourth is a single-cycle warm-reset pulse that tells the rest of the function to re-initialise after it wakes from D3hot. A pending interrupt from the function's sources is routed either to an MSI request line or to the INTx line, according to the gate and the MSI enable bit.

Top module: `pcfg_pm_msi_regs`

## Requirements
- R1: Every request with `cfg_req` high is answered by `cfg_ack` high in the following cycle, whether it is a read or a write and whether or not the data is taken. `cfg_ack` is low in any cycle that follows a cycle without a request.
- R2: A read of the power dword (dword address 15h) returns the state in bits 1:0 and zero in all other bits. The code 00 means D0 and 11 means D3hot. The state after reset is D0.
- R3: A write of 01 or 10 to bits 1:0 of the power dword is acknowledged normally, but the power state stays unchanged.
- R4: While in D3hot, `decode_en`, `irq_gate`, `msi_req` and `intx` are all low, and config reads and writes still work.
- R5: A write with `cfg_be[0]` set that moves the state from D3hot to D0 makes `warm_rst` high for exactly the cycle in which the acknowledge is high. In that same cycle MSI enable reads back as 0. A write of 00 while already in D0 gives no pulse.
- R6: Bits 15:0 of the MSI dword (dword address 18h) read 7005h: capability ID 05h in bits 7:0 and next pointer 70h in bits 15:8. Writes do not change them.
- R7: Bits 31:16 of the MSI dword hold the message control word. Bit 23 always reads 1 (64-bit address capable). Bits 31:24 and bits 22:17 read 0. The word reads 0080h after reset.
- R8: MSI enable is bit 16 of the MSI dword. It changes only on a write with `cfg_be[2]` set. The power state changes only on a write with `cfg_be[0]` set.
- R9: `msi_sel` equals MSI enable. `msi_req` is high exactly when the gate is open, MSI enable is 1 and any bit of `irq_src` is set. `intx` is high exactly when the gate is open, MSI enable is 0 and any bit of `irq_src` is set.
- R10: `decode_en` equals `decode_req` while in D0. `irq_gate` is high exactly in D0.
- R11: A read of any other dword address returns zero, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Config access request, one cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Dword address in config space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | Acknowledge, one cycle after the request |
| cfg_rdata | output | 32 | Read data, valid with the acknowledge of a read |
| decode_req | input | 1 | Memory/IO decode request from the command logic |
| irq_src | input | N_IRQ | Pending interrupt sources |
| decode_en | output | 1 | Gated memory/IO decode enable |
| irq_gate | output | 1 | Interrupt gate, open in D0 |
| msi_sel | output | 1 | 1 = signal interrupts by MSI, 0 = by INTx |
| msi_req | output | 1 | MSI request |
| intx | output | 1 | INTx level |
| warm_rst | output | 1 | One-cycle internal warm-reset pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit dword address, the power dword at 15h, the MSI dword at 18h, the 64-bit capability option set and four interrupt sources. The six-bit address lets random accesses reach the unmapped dwords alongside the two live ones. The four-wide source vector lets single and mixed pending patterns drive the routing. Directed sequences walk D0 to D3hot and back with MSI enabled, which brings the wake pulse and its clearing of MSI enable within reach. Random accesses with reserved power codes and partial byte enables cover the discard and masking paths.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
   localparam logic [1:0] PS_D0    = 2'b00;
   localparam logic [1:0] PS_D3HOT = 2'b11;

   function automatic logic ps_code_ok(input logic [1:0] code);
      return (code == PS_D0) || (code == PS_D3HOT);
   endfunction
endpackage

// File: rtl/pcfg_pwr_state.sv
module pcfg_pwr_state
   import pcfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [1:0] wr_code,
   output logic [1:0] ps_o,
   output logic       wake_o,
   output logic       warm_rst_o
);
   logic [1:0] ps_q;
   logic       take;

   assign take   = wr_stb && ps_code_ok(wr_code);
   assign wake_o = take && (ps_q == PS_D3HOT) && (wr_code == PS_D0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q       <= PS_D0;
         warm_rst_o <= 1'b0;
      end else begin
         if (take) ps_q <= wr_code;
         warm_rst_o <= wake_o;
      end
   end

   assign ps_o = ps_q;
endmodule

// File: rtl/pcfg_msi_ctrl.sv
module pcfg_msi_ctrl #(
   parameter bit ADDR64_CAP = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic        wr_en_bit,
   input  logic        clr,
   output logic        msi_en_o,
   output logic [15:0] ctrl_word_o
);
   logic msi_en_q;
   logic cap64;

   generate
      if (ADDR64_CAP) begin : g_cap64
         assign cap64 = 1'b1;
      end else begin : g_cap32
         assign cap64 = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msi_en_q <= 1'b0;
      else if (clr)    msi_en_q <= 1'b0;
      else if (wr_stb) msi_en_q <= wr_en_bit;
   end

   assign msi_en_o    = msi_en_q;
   assign ctrl_word_o = {8'h00, cap64, 3'b000, 3'b000, msi_en_q};
endmodule

// File: rtl/pcfg_irq_route.sv
module pcfg_irq_route
   import pcfg_pkg::*;
#(
   parameter int N_IRQ = 4
) (
   input  logic [1:0]       ps,
   input  logic             msi_en,
   input  logic             decode_req,
   input  logic [N_IRQ-1:0] irq_src,
   output logic             decode_en,
   output logic             irq_gate,
   output logic             msi_sel,
   output logic             msi_req,
   output logic             intx
);
   logic awake;
   logic pending;

   assign awake     = (ps == PS_D0);
   assign pending   = |irq_src;
   assign decode_en = awake && decode_req;
   assign irq_gate  = awake;
   assign msi_sel   = msi_en;
   assign msi_req   = awake && msi_en && pending;
   assign intx      = awake && !msi_en && pending;
endmodule

// File: rtl/pcfg_pm_msi_regs.sv
module pcfg_pm_msi_regs #(
   parameter int          ADDR_W     = 6,
   parameter int          PM_DW      = 'h15,
   parameter int          MSI_DW     = 'h18,
   parameter logic [7:0]  CAP_ID     = 8'h05,
   parameter logic [7:0]  NEXT_PTR   = 8'h70,
   parameter bit          ADDR64_CAP = 1'b1,
   parameter int          N_IRQ      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_ack,
   output logic [31:0]       cfg_rdata,
   input  logic              decode_req,
   input  logic [N_IRQ-1:0]  irq_src,
   output logic              decode_en,
   output logic              irq_gate,
   output logic              msi_sel,
   output logic              msi_req,
   output logic              intx,
   output logic              warm_rst
);
   localparam logic [ADDR_W-1:0] PM_A  = ADDR_W'(PM_DW);
   localparam logic [ADDR_W-1:0] MSI_A = ADDR_W'(MSI_DW);

   generate
      if (PM_DW == MSI_DW) begin : g_err_overlap
         initial $error("power and MSI dwords overlap");
      end
      if ((PM_DW >= (1 << ADDR_W)) || (MSI_DW >= (1 << ADDR_W))) begin : g_err_range
         initial $error("register dword outside address range");
      end
      if (N_IRQ < 1) begin : g_err_irq
         initial $error("N_IRQ must be at least 1");
      end
   endgenerate

   logic        hit_pm, hit_msi;
   logic        pm_wr, msi_wr;
   logic [1:0]  ps_q;
   logic        wake;
   logic        msi_en;
   logic [15:0] msg_ctrl;
   logic [31:0] rd_next;
   logic        unused_ok;

   assign hit_pm  = (cfg_addr == PM_A);
   assign hit_msi = (cfg_addr == MSI_A);
   assign pm_wr   = cfg_req && cfg_we && hit_pm  && cfg_be[0];
   assign msi_wr  = cfg_req && cfg_we && hit_msi && cfg_be[2];
   assign unused_ok = ^{cfg_wdata[31:17], cfg_wdata[15:2], cfg_be[3], cfg_be[1]};

   pcfg_pwr_state i_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (pm_wr),
      .wr_code    (cfg_wdata[1:0]),
      .ps_o       (ps_q),
      .wake_o     (wake),
      .warm_rst_o (warm_rst)
   );

   pcfg_msi_ctrl #(.ADDR64_CAP(ADDR64_CAP)) i_msi (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (msi_wr),
      .wr_en_bit   (cfg_wdata[16]),
      .clr         (wake),
      .msi_en_o    (msi_en),
      .ctrl_word_o (msg_ctrl)
   );

   pcfg_irq_route #(.N_IRQ(N_IRQ)) i_route (
      .ps         (ps_q),
      .msi_en     (msi_en),
      .decode_req (decode_req),
      .irq_src    (irq_src),
      .decode_en  (decode_en),
      .irq_gate   (irq_gate),
      .msi_sel    (msi_sel),
      .msi_req    (msi_req),
      .intx       (intx)
   );

   always_comb begin
      rd_next = '0;
      if (hit_pm)       rd_next[1:0] = ps_q;
      else if (hit_msi) rd_next      = {msg_ctrl, NEXT_PTR, CAP_ID};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ack   <= 1'b0;
         cfg_rdata <= '0;
      end else begin
         cfg_ack   <= cfg_req;
         cfg_rdata <= (cfg_req && !cfg_we) ? rd_next : 32'h0;
      end
   end
endmodule

// File: rtl/pcfg_pm_msi_chk.sv
module pcfg_pm_msi_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_req,
   input logic       cfg_ack,
   input logic [1:0] pstate,
   input logic       decode_en,
   input logic       irq_gate,
   input logic       msi_sel,
   input logic       msi_req,
   input logic       intx,
   input logic       warm_rst
);
   AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> cfg_ack); // R1
   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_req |=> !cfg_ack); // R1
   AST_PS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b00) || (pstate == 2'b11)); // R3
   AST_D3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 2'b11) |-> (!decode_en && !irq_gate && !msi_req && !intx)); // R4
   AST_WARM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |-> ($past(pstate) == 2'b11 && pstate == 2'b00 && !msi_sel)); // R5
   AST_WARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> !warm_rst); // R5
   AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(msi_req && intx)); // R9
   AST_MSI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |-> (msi_sel && irq_gate)); // R9
endmodule

bind pcfg_pm_msi_regs pcfg_pm_msi_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_req   (cfg_req),
   .cfg_ack   (cfg_ack),
   .pstate    (ps_q),
   .decode_en (decode_en),
   .irq_gate  (irq_gate),
   .msi_sel   (msi_sel),
   .msi_req   (msi_req),
   .intx      (intx),
   .warm_rst  (warm_rst)
);

// File: tb/test_pcfg_pm_msi_regs.sv
module test_pcfg_pm_msi_regs;
   localparam int ADDR_W = 6;
   localparam int N_IRQ  = 4;
   localparam logic [ADDR_W-1:0] PM_A  = 6'h15;
   localparam logic [ADDR_W-1:0] MSI_A = 6'h18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_req = 1'b0, cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [3:0]        cfg_be = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              cfg_ack;
   logic [31:0]       cfg_rdata;
   logic              decode_req = 1'b0;
   logic [N_IRQ-1:0]  irq_src = '0;
   logic decode_en, irq_gate, msi_sel, msi_req, intx, warm_rst;

   int total = 0;
   int bad   = 0;
   logic [1:0] m_ps  = 2'b00;
   logic       m_msi = 1'b0;

   always #4 clk = ~clk;

   pcfg_pm_msi_regs i_pcfg_pm_msi_regs (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .decode_req(decode_req),
      .irq_src(irq_src), .decode_en(decode_en), .irq_gate(irq_gate),
      .msi_sel(msi_sel), .msi_req(msi_req), .intx(intx), .warm_rst(warm_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
      if (a == PM_A)  return {30'h0, m_ps};
      if (a == MSI_A) return {16'h0080 | {15'h0, m_msi}, 16'h7005};
      return 32'h0;
   endfunction

   task automatic check_outputs();
      logic awake;
      logic pend;
      awake = (m_ps == 2'b00);
      pend  = |irq_src;
      chk("R10 decode_en", {31'h0, decode_en}, {31'h0, awake & decode_req});
      chk("R4 irq_gate", {31'h0, irq_gate}, {31'h0, awake});
      chk("R9 msi_sel", {31'h0, msi_sel}, {31'h0, m_msi});
      chk("R9 msi_req", {31'h0, msi_req}, {31'h0, awake & m_msi & pend});
      chk("R9 intx", {31'h0, intx}, {31'h0, awake & ~m_msi & pend});
   endtask

   task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                         input logic [3:0] be, input logic [31:0] wd);
      logic [31:0] er;
      logic        ew;
      @(negedge clk);
      chk("R1 idle ack", {31'h0, cfg_ack}, 32'h0);
      cfg_req = 1'b1; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
      er = exp_read(a);
      ew = 1'b0;
      if (we && a == PM_A && be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) begin
         if (m_ps == 2'b11 && wd[1:0] == 2'b00) begin
            ew = 1'b1;
            m_msi = 1'b0;
         end
         m_ps = wd[1:0];
      end
      if (we && a == MSI_A && be[2]) m_msi = wd[16];
      @(negedge clk);
      chk("R1 ack", {31'h0, cfg_ack}, 32'h1);
      chk("R5 warm_rst", {31'h0, warm_rst}, {31'h0, ew});
      if (!we) chk("R2 R6 R7 R11 rdata", cfg_rdata, er);
      cfg_req = 1'b0; cfg_we = 1'b0;
      decode_req = 1'($urandom_range(0, 1));
      irq_src    = N_IRQ'($urandom_range(0, 15));
      #1;
      check_outputs();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk("R1 reset ack", {31'h0, cfg_ack}, 32'h0);
      chk("R5 reset warm", {31'h0, warm_rst}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, PM_A, 4'h0, 32'h0);               // R2 reset D0
      access(1'b0, MSI_A, 4'h0, 32'h0);              // R6 R7 reset 0080h/7005h
      access(1'b1, MSI_A, 4'hF, 32'hFFFE_FFFF);      // R6 R7 RO bits, R8 en stays 0
      access(1'b0, MSI_A, 4'h0, 32'h0);
      access(1'b1, MSI_A, 4'hB, 32'h0001_0000);      // R8 be[2] clear: ignored
      access(1'b0, MSI_A, 4'h0, 32'h0);
      access(1'b1, MSI_A, 4'h4, 32'h0001_0000);      // R8 enable
      access(1'b0, MSI_A, 4'h0, 32'h0);
      access(1'b1, PM_A, 4'hF, 32'h0000_0001);       // R3 reserved 01
      access(1'b1, PM_A, 4'hF, 32'h0000_0002);       // R3 reserved 10
      access(1'b1, PM_A, 4'hE, 32'h0000_0003);       // R8 be[0] clear
      access(1'b1, PM_A, 4'h1, 32'h0000_0000);       // R5 D0->D0 no pulse
      access(1'b1, PM_A, 4'h1, 32'h0000_0003);       // R4 enter D3hot
      access(1'b0, PM_A, 4'h0, 32'h0);               // R4 config still readable
      access(1'b1, PM_A, 4'h1, 32'h0000_0002);       // R3 reserved in D3hot
      access(1'b1, PM_A, 4'h1, 32'h0000_0003);       // R5 D3->D3 no pulse
      access(1'b1, PM_A, 4'h1, 32'h0000_0000);       // R5 wake pulse clears MSI
      access(1'b0, MSI_A, 4'h0, 32'h0);
      access(1'b1, 6'h00, 4'hF, 32'hFFFF_FFFF);      // R11 unmapped write
      access(1'b0, 6'h00, 4'h0, 32'h0);              // R11 unmapped read
      for (int i = 0; i < 400; i++) begin
         logic [ADDR_W-1:0] a;
         int sel;
         sel = $urandom_range(0, 4);
         a = (sel < 2) ? PM_A : (sel < 4) ? MSI_A : ADDR_W'($urandom_range(0, 63));
         access(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)), $urandom);
      end
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule